// File: doc/BRIEF.md
# Group-Complement Worst-Crosstalk Bus Encoder and Decoder

This block protects a parallel on-chip bus against its worst coupling case. That case occurs when a wire switches while both of its neighbours switch the other way between two consecutive bus words. The wire then sees four times the inter-wire coupling capacitance, and this is what limits the bus's top data rate. The data word is cut into 3-bit groups. Each group travels on four wires: three data wires and one polarity flag. The flag tells the receiver whether the three data wires carry the group as-is or inverted. The cost is one extra wire for every three, a 33% overhead.

The encoder keeps the last word it drove onto the bus and settles the groups one at a time, starting from the least significant group. For each group it first tries the plain polarity against the old word and against the wires already chosen for the group below. If the plain polarity would create an opposed-neighbour transition, it tries the inverted polarity. This order means that a conflict across the boundary between two groups is settled before the next group is looked at. If neither polarity is clean, the encoder sends the plain form and raises an error flag that stays set until reset. The decoder in the same block takes the coded bus and undoes the inversion group by group.

Top module: `xtk_codec`

## Requirements
- R1: Group g occupies bus wires 4g..4g+3. Wire 4g+3 is the polarity flag. Wire 4g+k (k=0..2) equals data bit 3g+k XOR the flag.
- R2: Two consecutive coded words never show a wire that switches while both of its neighbours switch the opposite way, unless the later word was flagged as unresolvable.
- R3: Each group is sent with the flag at 0 when that polarity is clean. Otherwise it is sent with the flag at 1 when that polarity is clean. If neither polarity is clean, the flag is 0 and the word is marked unresolvable.
- R4: A group's check covers the four centre wires from 4g-1 to 4g+2. It uses the previous word and the wires already chosen for the group below it in the same word.
- R5: A word accepted with `in_valid` high appears on `bus_out` one clock later, with `bus_valid` high for that cycle.
- R6: While `in_valid` is low, `bus_out` holds its last value and `bus_valid` stays low the following cycle.
- R7: `dec_data` equals the accepted input word two clocks after acceptance, with `dec_valid` high in that cycle.
- R8: `err_sticky` goes high with the first unresolvable word and stays high until reset.
- R9: Reset drives `bus_out` to all zeros (all flags at 0) and drives `bus_valid`, `dec_valid` and `err_sticky` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 3*NG | Input data word |
| bus_out | output | 4*NG | Coded bus word (data wires plus polarity flags) |
| bus_valid | output | 1 | A new coded word is on the bus |
| dec_data | output | 3*NG | Decoded data word |
| dec_valid | output | 1 | Decoded word is valid |
| err_sticky | output | 1 | An unresolvable word has been sent since reset |

## Verification
The bench builds the block with NG=4: twelve data bits on sixteen wires, with three internal group boundaries. This gives boundary conflicts that ripple upward from group 0 into groups 1 to 3, and the edge wires at both ends of the bus. A directed pair of words forces a group-0 inversion. Long random runs with idle gaps exercise the polarity priority, the holding of the bus while idle, and the round trip through the decoder. The whole encoding is compared against an independent reference model in the bench.

// File: rtl/xtk_pkg.sv
package xtk_pkg;

  // Opposed-neighbour transition on the middle wire of a 3-wire slice.
  function automatic logic opp_mid(input logic [2:0] p, input logic [2:0] c);
    logic [2:0] up;
    logic [2:0] dn;
    up = ~p & c;
    dn = p & ~c;
    return (up[1] & dn[0] & dn[2]) | (dn[1] & up[0] & up[2]);
  endfunction

  // 6-wire window: two wires below the group plus the group's four wires.
  // Centres at window bits 1..4 are checked.
  function automatic logic window_clean(input logic [5:0] p, input logic [5:0] c);
    logic bad;
    bad = 1'b0;
    for (int k = 1; k <= 4; k++) bad |= opp_mid(p[k-1 +: 3], c[k-1 +: 3]);
    return !bad;
  endfunction

endpackage

// File: rtl/xtk_grp_pick.sv
module xtk_grp_pick
  import xtk_pkg::*;
(
  input  logic [1:0] prev_lo,
  input  logic [1:0] cur_lo,
  input  logic [3:0] prev_grp,
  input  logic [2:0] dat,
  output logic [3:0] wires,
  output logic       inv,
  output logic       stuck
);
  logic [3:0] plain_w;
  logic [3:0] flip_w;
  logic       plain_ok;
  logic       flip_ok;

  assign plain_w  = {1'b0, dat};
  assign flip_w   = {1'b1, ~dat};
  assign plain_ok = window_clean({prev_grp, prev_lo}, {plain_w, cur_lo});
  assign flip_ok  = window_clean({prev_grp, prev_lo}, {flip_w, cur_lo});

  // R3: plain first, then inverted, else plain with failure
  assign inv   = !plain_ok && flip_ok;
  assign stuck = !plain_ok && !flip_ok;
  assign wires = inv ? flip_w : plain_w;
endmodule

// File: rtl/xtk_encoder.sv
module xtk_encoder
  import xtk_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3*NG-1:0] in_data,
  output logic [4*NG-1:0] bus_q,
  output logic            bus_vld,
  output logic            word_fail,
  output logic            err_sticky
);
  localparam int BW = 4 * NG;

  logic [BW-1:0] pick;
  logic [NG-1:0] stuck_g;
  logic [NG-1:0] inv_g;

  // R4: groups chained from the LSB end through the chosen lower wires
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [1:0] plo;
    logic [1:0] clo;
    if (g == 0) begin : g_edge
      assign plo = 2'b00;
      assign clo = 2'b00;
    end else begin : g_inner
      assign plo = bus_q[4*g-1 -: 2];
      assign clo = pick[4*g-1 -: 2];
    end
    xtk_grp_pick u_pick (
      .prev_lo (plo),
      .cur_lo  (clo),
      .prev_grp(bus_q[4*g +: 4]),
      .dat     (in_data[3*g +: 3]),
      .wires   (pick[4*g +: 4]),
      .inv     (inv_g[g]),
      .stuck   (stuck_g[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q      <= '0;
      bus_vld    <= 1'b0;
      word_fail  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      bus_vld <= in_valid;
      if (in_valid) begin
        bus_q      <= pick;
        word_fail  <= |stuck_g;
        err_sticky <= err_sticky | (|stuck_g);
      end
    end
  end

  function automatic logic bus_has_opp(input logic [BW-1:0] p, input logic [BW-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 1; i < BW - 1; i++) hit |= opp_mid(p[i-1 +: 3], c[i-1 +: 3]);
    return hit;
  endfunction

  assert_no_4c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !word_fail) |-> !bus_has_opp($past(bus_q), bus_q));
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> bus_vld);
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bus_q) && !bus_vld));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

// File: rtl/xtk_decoder.sv
module xtk_decoder #(
  parameter int NG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4*NG-1:0] bus_in,
  input  logic            bus_vld,
  output logic [3*NG-1:0] dat_q,
  output logic            dat_vld
);
  localparam int DW = 3 * NG;

  logic [DW-1:0] restored;

  // R1: each group's data wires XOR its flag
  for (genvar g = 0; g < NG; g++) begin : g_undo
    assign restored[3*g +: 3] = bus_in[4*g +: 3] ^ {3{bus_in[4*g+3]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q   <= '0;
      dat_vld <= 1'b0;
    end else begin
      dat_vld <= bus_vld;
      if (bus_vld) dat_q <= restored;
    end
  end
endmodule

// File: rtl/xtk_codec.sv
module xtk_codec #(
  parameter int NG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3*NG-1:0] in_data,
  output logic [4*NG-1:0] bus_out,
  output logic            bus_valid,
  output logic [3*NG-1:0] dec_data,
  output logic            dec_valid,
  output logic            err_sticky
);
  logic word_fail;

  xtk_encoder #(.NG(NG)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .bus_q     (bus_out),
    .bus_vld   (bus_valid),
    .word_fail (word_fail),
    .err_sticky(err_sticky)
  );

  xtk_decoder #(.NG(NG)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_in (bus_out),
    .bus_vld(bus_valid),
    .dat_q  (dec_data),
    .dat_vld(dec_valid)
  );

  assert_roundtrip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($past(in_valid, 2) && dec_data == $past(in_data, 2)));
  assert_reset_flags_R9: assert property (@(posedge clk)
    !rst_n |=> (!bus_valid && !dec_valid && !err_sticky && bus_out == '0));
endmodule

// File: tb/tb_xtk_codec.sv
module tb_xtk_codec;
  localparam int NG = 4;
  localparam int DW = 3 * NG;
  localparam int BW = 4 * NG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [BW-1:0] bus_out;
  logic          bus_valid;
  logic [DW-1:0] dec_data;
  logic          dec_valid;
  logic          err_sticky;

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [BW-1:0] exp_bus_q[$];
  logic          exp_err_q[$];
  logic          exp_fail_q[$];
  logic [DW-1:0] bus_dat_q[$];
  logic [DW-1:0] dec_exp_q[$];

  logic [BW-1:0] m_prev = '0;
  logic          m_err = 1'b0;
  logic [BW-1:0] last_bus = '0;

  always #2.5 clk = ~clk;

  xtk_codec #(.NG(NG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_out(bus_out), .bus_valid(bus_valid), .dec_data(dec_data),
    .dec_valid(dec_valid), .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // wire i switches against both neighbours
  function automatic bit clash(input logic [BW-1:0] p, input logic [BW-1:0] c, input int i);
    bit mid_up, mid_dn, lo_up, lo_dn, hi_up, hi_dn;
    mid_up = !p[i] && c[i];     mid_dn = p[i] && !c[i];
    lo_up  = !p[i-1] && c[i-1]; lo_dn  = p[i-1] && !c[i-1];
    hi_up  = !p[i+1] && c[i+1]; hi_dn  = p[i+1] && !c[i+1];
    return (mid_up && lo_dn && hi_dn) || (mid_dn && lo_up && hi_up);
  endfunction

  // reference encoder, restated as a prefix search over trial buses
  task automatic model_word(input logic [DW-1:0] d, output logic [BW-1:0] word, output bit fail);
    logic [BW-1:0] trial;
    word = '0;
    fail = 1'b0;
    for (int g = 0; g < NG; g++) begin
      bit clean[2];
      int lo;
      lo = (g == 0) ? 1 : 4 * g - 1;
      for (int pol = 0; pol < 2; pol++) begin
        trial = word;
        for (int k = 0; k < 3; k++) trial[4*g+k] = d[3*g+k] ^ pol[0];
        trial[4*g+3] = pol[0];
        clean[pol] = 1'b1;
        for (int i = lo; i <= 4 * g + 2; i++)
          if (clash(m_prev, trial, i)) clean[pol] = 1'b0;
      end
      if (!clean[0] && clean[1]) begin
        for (int k = 0; k < 3; k++) word[4*g+k] = ~d[3*g+k];
        word[4*g+3] = 1'b1;
      end else begin
        for (int k = 0; k < 3; k++) word[4*g+k] = d[3*g+k];
        word[4*g+3] = 1'b0;
        if (!clean[0]) fail = 1'b1;
      end
    end
  endtask

  task automatic send(input logic [DW-1:0] d);
    logic [BW-1:0] w;
    bit f;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    model_word(d, w, f);
    m_err  = m_err | f;
    m_prev = w;
    exp_bus_q.push_back(w);
    exp_err_q.push_back(m_err);
    exp_fail_q.push_back(f);
    bus_dat_q.push_back(d);
    dec_exp_q.push_back(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      if (bus_valid) begin
        logic [BW-1:0] eb;
        logic [DW-1:0] ed;
        logic          ee;
        bit            ef;
        bit            any;
        if (exp_bus_q.size() == 0) begin
          chk(1'b0, "R5 unexpected bus_valid", 64'(bus_out), 64'd0);
        end else begin
          eb = exp_bus_q.pop_front();
          ee = exp_err_q.pop_front();
          ef = exp_fail_q.pop_front();
          ed = bus_dat_q.pop_front();
          chk(bus_out === eb, "R3/R4 coded word", 64'(bus_out), 64'(eb));
          chk(err_sticky === ee, "R8 err_sticky", 64'(err_sticky), 64'(ee));
          for (int g = 0; g < NG; g++)
            chk((bus_out[4*g +: 3] ^ {3{bus_out[4*g+3]}}) === ed[3*g +: 3],
                "R1 group layout", 64'(bus_out[4*g +: 4]), 64'(ed[3*g +: 3]));
          if (!ef) begin
            any = 1'b0;
            for (int i = 1; i < BW - 1; i++) if (clash(last_bus, bus_out, i)) any = 1'b1;
            chk(!any, "R2 no opposed-neighbour switch", 64'(bus_out), 64'(last_bus));
          end
        end
        last_bus = bus_out;
      end else begin
        chk(bus_out === last_bus, "R6 bus holds while idle", 64'(bus_out), 64'(last_bus));
      end
      if (dec_valid) begin
        logic [DW-1:0] xd;
        if (dec_exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected dec_valid", 64'(dec_data), 64'd0);
        end else begin
          xd = dec_exp_q.pop_front();
          chk(dec_data === xd, "R7 decoded data", 64'(dec_data), 64'(xd));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(bus_out === '0, "R9 reset bus", 64'(bus_out), 64'd0);
    chk(!bus_valid && !dec_valid, "R9 reset valids", 64'({bus_valid, dec_valid}), 64'd0);
    chk(err_sticky === 1'b0, "R9 reset err", 64'(err_sticky), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;

    // R3 directed: 101 then 010 on group 0 forces inversion
    send(12'h005);
    send(12'h002);
    idle(1);
    chk(bus_valid === 1'b1, "R5 bus_valid after accept", 64'(bus_valid), 64'd1);
    chk(bus_out[3] === 1'b1, "R3 group0 inverted", 64'(bus_out[3:0]), 64'hd);
    idle(3);

    // patterns
    send('1); send('0); send({NG{3'b101}}); send({NG{3'b010}});
    send({NG{3'b101}}); send(12'hAAA); send(12'h555); send(12'hAAA);
    idle(2);
    for (int i = 0; i < DW; i++) send(DW'(1) << i);
    for (int i = 0; i < DW; i++) send(~(DW'(1) << i));
    idle(3);

    // random stream with gaps
    for (int n = 0; n < 3000; n++) begin
      r = DW'($urandom);
      send(r);
      if (($urandom % 7) == 0) idle(1 + ($urandom % 3));
    end
    idle(5);
    chk(exp_bus_q.size() == 0 && dec_exp_q.size() == 0, "R7 scoreboard drained",
        64'(exp_bus_q.size() + dec_exp_q.size()), 64'd0);

    // R9: reset again clears the sticky flag and bus
    rst_n = 1'b0;
    running = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(bus_out === '0 && !err_sticky, "R9 re-reset", 64'({err_sticky, bus_out}), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule